// File: doc/BRIEF.md
# GPIO Port Register Bank with Pin-Function Muxing

This block controls one port of general-purpose pins. Software reaches it over a simple single-cycle bus with separate read and write strobes. There are five configuration registers, one bit per pin in each. Every configuration register has three addresses: a plain address that replaces the whole word, a set alias at base+4 and a clear alias at base+8. Writing a 1 through an alias sets or clears that bit. Writing a 0 through an alias leaves the bit as it is, so software can change a single pin without a read-modify-write.

For each pin, four of those bits (interrupt-select, mask, pattern-high and pattern-low) are decoded into one of seven pin modes: PM_FUNC0, PM_FUNC1, PM_FUNC2, PM_FUNC3, PM_GPIO_IN, PM_GPIO_OUT and PM_IRQ. The mode decides what reaches the pad.
- A function mode routes the matching peripheral's output enable and data to the pad.
- PM_GPIO_OUT drives the pattern-low bit onto the pad.
- PM_GPIO_IN and PM_IRQ release the pad.

Going from one mode to another is a transition through a register write. A mode is left only when one of the four bits is rewritten, and the new mode takes effect in the cycle after the write edge. The raw interrupt configuration is handed to a separate edge/level detector. The fifth register, pull-disable, drives the pull-resistor control lines.

Pad levels pass through a two-flop synchronizer. The synchronized word is readable at offset 0x000 and is also exported.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, for every pin: interrupt-select=0, mask=1, pattern-high=1, pattern-low=0 and pull-disable=0. As a result every pin is a GPIO input and pad_oe is all zero.
- R2: A write to a plain address replaces the register: interrupt-select 0x010, mask 0x020, pattern-high 0x030, pattern-low 0x040, pull-disable 0x070. A read of a plain address returns the register on bus_rdata in the cycle after the read edge.
- R3: A write to base+4 sets the bits written as 1. A write to base+8 clears the bits written as 1. Bits written as 0 keep their value.
- R4: With interrupt-select=0 and mask=0, the function number is {pattern-high, pattern-low}. Function f drives pad_oe[p]=func_oe[f*NPINS+p] and pad_out[p]=func_dout[f*NPINS+p].
- R5: With interrupt-select=0, mask=1 and pattern-high=0, the pin is an output: pad_oe=1 and pad_out equals pattern-low.
- R6: With interrupt-select=0, mask=1 and pattern-high=1, the pin is an input: pad_oe=0 and pad_out=0.
- R7: With interrupt-select=1, pad_oe=0 and pad_out=0. The outputs irq_sel, irq_msk, irq_pat1 and irq_pat0 always carry the raw interrupt-select, mask, pattern-high and pattern-low registers.
- R8: pull_off mirrors the pull-disable register. A 1 turns the pull resistor off.
- R9: pin_level is pad_in delayed by two clock edges. A read of 0x000 returns pin_level as it stood at the read edge. Writes to 0x000 change nothing.
- R10: Reads of alias addresses and of unmapped offsets return 0. Writes to unmapped offsets change nothing. bus_rdata is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, registered |
| pad_in | input | NPINS | Raw pad levels |
| func_oe | input | 4*NPINS | Peripheral output enables, function-major |
| func_dout | input | 4*NPINS | Peripheral output data, function-major |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad output value |
| pull_off | output | NPINS | Pull resistor disable |
| pin_level | output | NPINS | Synchronized pad levels |
| irq_sel | output | NPINS | Interrupt-select bits |
| irq_msk | output | NPINS | Mask bits |
| irq_pat1 | output | NPINS | Pattern-high bits |
| irq_pat0 | output | NPINS | Pattern-low bits |

## Verification
The bench builds the block with its defaults: NPINS=32, ADDR_W=8 and SYNC_STAGES=2. With full 32-bit words, alias writes can touch both the top and bottom pins at once. Eight neighbouring pins are placed in all four function modes together while the other pins stay in GPIO and interrupt modes. The 8-bit address reaches the whole 0x00–0xFC window, so unmapped holes and alias reads are exercised alongside the mapped registers. A behavioural model in the bench predicts every output on every clock, including the two-edge delay on the pin levels.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int NREG     = 5;
    localparam int NFUNC    = 4;
    localparam int IDX_INT  = 0;
    localparam int IDX_MSK  = 1;
    localparam int IDX_PAT1 = 2;
    localparam int IDX_PAT0 = 3;
    localparam int IDX_PULL = 4;

    localparam logic [7:0] OFS_LEVEL = 8'h00;
    localparam logic [7:0] OFS_SET   = 8'h04;
    localparam logic [7:0] OFS_CLR   = 8'h08;

    typedef enum logic [2:0] {
        PM_FUNC0,
        PM_FUNC1,
        PM_FUNC2,
        PM_FUNC3,
        PM_GPIO_IN,
        PM_GPIO_OUT,
        PM_IRQ
    } pin_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_PLAIN,
        ACC_SET,
        ACC_CLR
    } acc_e;

    function automatic logic [7:0] reg_base(input int idx);
        case (idx)
            IDX_INT:  return 8'h10;
            IDX_MSK:  return 8'h20;
            IDX_PAT1: return 8'h30;
            IDX_PAT0: return 8'h40;
            default:  return 8'h70;
        endcase
    endfunction

    function automatic logic reg_rst_ones(input int idx);
        return (idx == IDX_MSK) || (idx == IDX_PAT1);
    endfunction

endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_e              wr_acc [NREG],
    output logic [NREG-1:0]   rd_hit,
    output logic              rd_level
);

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            wr_acc[i] = ACC_NONE;
            rd_hit[i] = 1'b0;
            if (bus_wr) begin
                if (bus_addr == ADDR_W'(reg_base(i)))
                    wr_acc[i] = ACC_PLAIN;
                else if (bus_addr == ADDR_W'(reg_base(i) + OFS_SET))
                    wr_acc[i] = ACC_SET;
                else if (bus_addr == ADDR_W'(reg_base(i) + OFS_CLR))
                    wr_acc[i] = ACC_CLR;
            end
            if (bus_rd && (bus_addr == ADDR_W'(reg_base(i))))
                rd_hit[i] = 1'b1;
        end
        rd_level = bus_rd && (bus_addr == ADDR_W'(OFS_LEVEL));
    end

endmodule

// File: rtl/gpb_cfg_reg.sv
module gpb_cfg_reg
    import gpb_pkg::*;
#(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_e         acc,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            unique case (acc)
                ACC_NONE:  q <= q;
                ACC_PLAIN: q <= wdata;
                ACC_SET:   q <= q | wdata;
                ACC_CLR:   q <= q & ~wdata;
            endcase
        end
    end

    p_plain_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_PLAIN) |=> (q == $past(wdata)));

    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_SET) |=> (((q & $past(wdata)) == $past(wdata)) &&
                              ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

    p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_CLR) |=> (((q & $past(wdata)) == '0) &&
                              ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_NONE) |=> $stable(q));

endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] warm;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              warm <= 2'd0;
                else if (warm != 2'd3)   warm <= warm + 2'd1;
            end
            p_two_edge_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (warm == 2'd3) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpb_pin_mux.sv
module gpb_pin_mux
    import gpb_pkg::*;
(
    input  logic             int_b,
    input  logic             msk_b,
    input  logic             pat1_b,
    input  logic             pat0_b,
    input  logic [NFUNC-1:0] f_oe,
    input  logic [NFUNC-1:0] f_do,
    output logic             oe,
    output logic             dout
);

    pin_mode_e mode;

    always_comb begin
        if (int_b) begin
            mode = PM_IRQ;
        end else if (!msk_b) begin
            unique case ({pat1_b, pat0_b})
                2'b00: mode = PM_FUNC0;
                2'b01: mode = PM_FUNC1;
                2'b10: mode = PM_FUNC2;
                2'b11: mode = PM_FUNC3;
            endcase
        end else begin
            mode = pat1_b ? PM_GPIO_IN : PM_GPIO_OUT;
        end
    end

    always_comb begin
        unique case (mode)
            PM_FUNC0:    begin oe = f_oe[0]; dout = f_do[0]; end
            PM_FUNC1:    begin oe = f_oe[1]; dout = f_do[1]; end
            PM_FUNC2:    begin oe = f_oe[2]; dout = f_do[2]; end
            PM_FUNC3:    begin oe = f_oe[3]; dout = f_do[3]; end
            PM_GPIO_OUT: begin oe = 1'b1;    dout = pat0_b;  end
            PM_GPIO_IN:  begin oe = 1'b0;    dout = 1'b0;    end
            default:     begin oe = 1'b0;    dout = 1'b0;    end
        endcase
    end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpb_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [NPINS-1:0]       bus_wdata,
    output logic [NPINS-1:0]       bus_rdata,
    input  logic [NPINS-1:0]       pad_in,
    input  logic [NFUNC*NPINS-1:0] func_oe,
    input  logic [NFUNC*NPINS-1:0] func_dout,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pull_off,
    output logic [NPINS-1:0]       pin_level,
    output logic [NPINS-1:0]       irq_sel,
    output logic [NPINS-1:0]       irq_msk,
    output logic [NPINS-1:0]       irq_pat1,
    output logic [NPINS-1:0]       irq_pat0
);

    acc_e             wr_acc [NREG];
    logic [NREG-1:0]  rd_hit;
    logic             rd_level;
    logic [NPINS-1:0] cfg_q [NREG];
    logic [NPINS-1:0] rd_val;

    gpb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .wr_acc   (wr_acc),
        .rd_hit   (rd_hit),
        .rd_level (rd_level)
    );

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            gpb_cfg_reg #(
                .W   (NPINS),
                .RST ({NPINS{reg_rst_ones(i)}})
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .acc   (wr_acc[i]),
                .wdata (bus_wdata),
                .q     (cfg_q[i])
            );
        end
    endgenerate

    gpb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_level)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            gpb_pin_mux u_mux (
                .int_b  (cfg_q[IDX_INT][p]),
                .msk_b  (cfg_q[IDX_MSK][p]),
                .pat1_b (cfg_q[IDX_PAT1][p]),
                .pat0_b (cfg_q[IDX_PAT0][p]),
                .f_oe   ({func_oe[3*NPINS+p], func_oe[2*NPINS+p],
                          func_oe[NPINS+p], func_oe[p]}),
                .f_do   ({func_dout[3*NPINS+p], func_dout[2*NPINS+p],
                          func_dout[NPINS+p], func_dout[p]}),
                .oe     (pad_oe[p]),
                .dout   (pad_out[p])
            );

            p_func_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_q[IDX_INT][p] && !cfg_q[IDX_MSK][p]) |->
                ((pad_oe[p] == func_oe[int'({cfg_q[IDX_PAT1][p], cfg_q[IDX_PAT0][p]})*NPINS + p]) &&
                 (pad_out[p] == func_dout[int'({cfg_q[IDX_PAT1][p], cfg_q[IDX_PAT0][p]})*NPINS + p])));
        end
    endgenerate

    always_comb begin
        rd_val = rd_level ? pin_level : '0;
        for (int i = 0; i < NREG; i++)
            if (rd_hit[i]) rd_val = rd_val | cfg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    assign pull_off = cfg_q[IDX_PULL];
    assign irq_sel  = cfg_q[IDX_INT];
    assign irq_msk  = cfg_q[IDX_MSK];
    assign irq_pat1 = cfg_q[IDX_PAT1];
    assign irq_pat0 = cfg_q[IDX_PAT0];

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_sel & pad_oe) == '0) && ((irq_sel & pad_out) == '0));

    p_gpio_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((~irq_sel & irq_msk & ~irq_pat1) & ~pad_oe) == '0) &&
        (((~irq_sel & irq_msk & ~irq_pat1) & (pad_out ^ irq_pat0)) == '0));

    p_gpio_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq_sel & irq_msk & irq_pat1) & (pad_oe | pad_out)) == '0);

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    p_level_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADDR_W'(OFS_LEVEL))) |=> (bus_rdata == $past(pin_level)));

endmodule

// File: tb/sim_gpio_port_bank.sv
`timescale 1ns/1ps
module sim_gpio_port_bank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = 32'h0;
    logic [31:0]  bus_rdata;
    logic [31:0]  pad_in = 32'h0;
    logic [127:0] func_oe = '0;
    logic [127:0] func_dout = '0;
    logic [31:0]  pad_oe, pad_out, pull_off, pin_level;
    logic [31:0]  irq_sel, irq_msk, irq_pat1, irq_pat0;

    int checks = 0;
    int fails = 0;
    bit chk_on = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .func_oe(func_oe), .func_dout(func_dout),
        .pad_oe(pad_oe), .pad_out(pad_out), .pull_off(pull_off),
        .pin_level(pin_level), .irq_sel(irq_sel), .irq_msk(irq_msk),
        .irq_pat1(irq_pat1), .irq_pat0(irq_pat0)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_int = 32'h0, m_msk = 32'hFFFF_FFFF, m_pat1 = 32'hFFFF_FFFF;
    logic [31:0] m_pat0 = 32'h0, m_pull = 32'h0;
    logic [31:0] m_s1 = 32'h0, m_s2 = 32'h0, m_rdata = 32'h0;
    string       m_rtag = "R10";

    function automatic logic [31:0] m_read(input logic [7:0] a, output string tag);
        tag = "R2";
        case (a)
            8'h00: begin tag = "R9"; return m_s2; end
            8'h10: return m_int;
            8'h20: return m_msk;
            8'h30: return m_pat1;
            8'h40: return m_pat0;
            8'h70: return m_pull;
            default: begin tag = "R10"; return 32'h0; end
        endcase
    endfunction

    function automatic logic [31:0] upd(input logic [31:0] old, input logic [1:0] kind,
                                        input logic [31:0] d);
        if (kind == 2'd0) return d;
        if (kind == 2'd1) return old | d;
        return old & ~d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_int = 0; m_msk = '1; m_pat1 = '1; m_pat0 = 0; m_pull = 0;
            m_s1 = 0; m_s2 = 0; m_rdata = 0; m_rtag = "R10";
        end else begin
            if (bus_rd) m_rdata = m_read(bus_addr, m_rtag);
            else begin m_rdata = 0; m_rtag = "R10"; end
            if (bus_wr) begin
                logic [1:0] kind;
                kind = (bus_addr[3:0] == 4'h0) ? 2'd0 : (bus_addr[3:0] == 4'h4) ? 2'd1 : 2'd2;
                if (bus_addr[3:0] == 4'h0 || bus_addr[3:0] == 4'h4 || bus_addr[3:0] == 4'h8) begin
                    case (bus_addr[7:4])
                        4'h1: m_int  = upd(m_int,  kind, bus_wdata);
                        4'h2: m_msk  = upd(m_msk,  kind, bus_wdata);
                        4'h3: m_pat1 = upd(m_pat1, kind, bus_wdata);
                        4'h4: m_pat0 = upd(m_pat0, kind, bus_wdata);
                        4'h7: m_pull = upd(m_pull, kind, bus_wdata);
                        default: ;
                    endcase
                end
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    function automatic string mode_tag(input int p);
        if (m_int[p])       return "R7";
        if (!m_msk[p])      return "R4";
        if (m_pat1[p])      return "R6";
        return "R5";
    endfunction

    always @(negedge clk) begin
        #1;
        if (chk_on) begin
            logic [31:0] e_oe, e_out;
            string t;
            t = "R5";
            for (int p = 0; p < 32; p++) begin
                int f;
                f = {m_pat1[p], m_pat0[p]};
                if (m_int[p])        begin e_oe[p] = 0; e_out[p] = 0; end
                else if (!m_msk[p])  begin e_oe[p] = func_oe[f*32+p]; e_out[p] = func_dout[f*32+p]; end
                else if (m_pat1[p])  begin e_oe[p] = 0; e_out[p] = 0; end
                else                 begin e_oe[p] = 1; e_out[p] = m_pat0[p]; end
            end
            for (int p = 0; p < 32; p++)
                if (pad_oe[p] !== e_oe[p] || pad_out[p] !== e_out[p]) begin
                    t = mode_tag(p);
                    break;
                end
            chk(t, pad_oe, e_oe);
            chk(t, pad_out, e_out);
            chk("R8", pull_off, m_pull);
            chk("R7", irq_sel, m_int);
            chk("R7", irq_msk, m_msk);
            chk("R7", irq_pat1, m_pat1);
            chk("R7", irq_pat0, m_pat0);
            chk("R9", pin_level, m_s2);
            chk(m_rtag, bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        #1 chk(tag, bus_rdata, exp);
    endtask

    logic [7:0] alist [19] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28,
                               8'h30, 8'h34, 8'h38, 8'h40, 8'h44, 8'h48, 8'h70,
                               8'h74, 8'h78, 8'h50, 8'hFC, 8'h0C};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        #1;
        chk("R1", pad_oe, 32'h0);
        chk("R1", pad_out, 32'h0);
        chk("R1", pull_off, 32'h0);
        rd(8'h10, 32'h0, "R1");
        rd(8'h20, 32'hFFFF_FFFF, "R1");
        rd(8'h30, 32'hFFFF_FFFF, "R1");
        rd(8'h40, 32'h0, "R1");
        rd(8'h70, 32'h0, "R1");

        // GPIO outputs on the upper half
        wr(8'h30, 32'h0000_FFFF);
        wr(8'h44, 32'hA5A5_0000);
        #1;
        chk("R5", pad_oe, 32'hFFFF_0000);
        chk("R5", pad_out, 32'hA5A5_0000);
        chk("R6", pad_oe & 32'h0000_FFFF, 32'h0);
        wr(8'h48, 32'h0505_0000);
        rd(8'h40, 32'hA0A0_0000, "R3");
        rd(8'h30, 32'h0000_FFFF, "R2");
        rd(8'h44, 32'h0, "R10");
        rd(8'h48, 32'h0, "R10");

        // Peripheral functions on pins 0..7
        func_oe   = {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF};
        func_dout = {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0};
        wr(8'h28, 32'h0000_00FF);
        wr(8'h38, 32'h0000_000F);
        wr(8'h44, 32'h0000_0033);
        #1;
        chk("R4", pad_oe, 32'hFFFF_00CC);
        chk("R4", pad_out, 32'hA0A0_0033);
        @(negedge clk);
        func_dout = {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF};
        #1;
        chk("R4", pad_out, 32'hA0A0_00CC);

        // Interrupt mode on the top four pins
        wr(8'h14, 32'hF000_0000);
        #1;
        chk("R7", pad_oe, 32'h0FFF_00CC);
        chk("R7", pad_out, 32'h00A0_00CC);
        chk("R7", irq_sel, 32'hF000_0000);
        chk("R7", irq_pat1, 32'h0000_FFF0);

        // Pull control
        wr(8'h74, 32'h1234_5678);
        wr(8'h78, 32'h0000_0678);
        #1 chk("R8", pull_off, 32'h1234_5000);
        wr(8'h70, 32'hFFFF_0000);
        #1 chk("R8", pull_off, 32'hFFFF_0000);

        // Pin level synchronizer and ignored writes
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        rd(8'h00, 32'h0, "R9");
        rd(8'h00, 32'hDEAD_BEEF, "R9");
        wr(8'h00, 32'h1234_5678);
        rd(8'h00, 32'hDEAD_BEEF, "R9");
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h10, 32'hF000_0000, "R10");
        rd(8'h20, 32'hFFFF_FF00, "R10");
        rd(8'hFC, 32'h0, "R10");
        rd(8'h50, 32'h0, "R10");

        // Random traffic against the model
        for (int k = 0; k < 600; k++) begin
            int sel;
            @(negedge clk);
            sel = $urandom_range(0, 2);
            bus_wr = (sel == 0);
            bus_rd = (sel == 1);
            bus_addr = alist[$urandom_range(0, 18)];
            bus_wdata = $urandom;
            if (k % 3 == 0) pad_in = $urandom;
            if (k % 7 == 0) begin
                func_oe   = {$urandom, $urandom, $urandom, $urandom};
                func_dout = {$urandom, $urandom, $urandom, $urandom};
            end
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule